// File: doc/BRIEF.md
# Configuration Space Address/Data Window

This block gives a host an indirect path into the configuration space of a few device functions through two registers. The host writes a 32-bit selector naming a bus, a device, a function and a byte offset. It then reads the data register and gets the configuration bytes found at that location. Each populated function has its own configuration store, loaded through a separate initialisation port before host traffic starts.

Each function also has a second store of the same size that holds size masks for its base-address registers. This supports the sizing handshake that enumeration software uses. The host writes all ones to a base-address register and then reads it back. That one read returns the size mask instead of the stored base value. Stored configuration contents never change through the host port.

A host of either byte order is supported. When `host_be` is set, the selector written by the host is fully byte-reversed before use. Data-port values are reversed across the bytes of the access, in both directions. The number of populated functions, their bus/device/function identities and the size of the configuration space are parameters.

Top module: `cfg_window`

## Requirements
- R1: A write with `host_ofs` = 0x0 loads the selector register with `host_wdata`, fully byte-reversed when `host_be` is 1. A read at offset 0x0 returns the selector as stored. The selector is 0 after reset.
- R2: The selector is decoded as bus = bits 23:16, device = bits 15:11, function = bits 10:8 and register offset = bits 7:0. A data-port read (`host_ofs` = 0x4) of a function whose tag `{bus,device,function}` appears in `FUNC_TAGS` returns that function's configuration bytes.
- R3: When no populated function matches, a data-port read returns 0xFFFFFFFF at register offset 0 and 0 at any other offset. Such a read leaves the sizing state unchanged.
- R4: `host_len_m1` encodes an access of 1 to 4 bytes (value + 1). The read result holds the byte at the register offset in bits 7:0, then the following bytes upward. Bytes beyond the access length are zero.
- R5: A data-port read with register offset + length greater than `CFG_BYTES` (64 by default) returns 0.
- R6: A 4-byte data-port write of 0xFFFFFFFF to a populated function, at a register offset from 0x10 to 0x24 inclusive, arms sizing. While sizing is armed, reads at offsets from 0x10 to 0x24 return the size-mask bytes instead of configuration bytes. Writes of other values, of other lengths, at other offsets, or to absent functions do not arm it.
- R7: Any data-port read of a populated function disarms sizing, whatever its offset.
- R8: Data-port writes never change configuration or size-mask contents.
- R9: With `host_be` = 1, data-port read results are byte-reversed across the access length. Data-port write values are reversed the same way before they are compared with all ones.
- R10: A read at any `host_ofs` other than 0x0 or 0x4 returns 0. A write at such an offset changes neither the selector nor the sizing state.
- R11: `host_rdata` and `host_rvalid` are registered. `host_rvalid` is 1 exactly in the cycle after a read request. `host_rdata` and `host_rvalid` are 0 after reset.
- R12: An initialisation write stores `init_wdata` as word `init_word` of function index `init_fn`. Byte 0 of the word is the lowest offset. `init_mask` = 1 selects the size-mask store and 0 selects the configuration store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_be | input | 1 | Host is big-endian |
| host_req | input | 1 | Host access request, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 4 | Port byte offset: 0x0 selector, 0x4 data |
| host_len_m1 | input | 2 | Access length in bytes minus one |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read result, one cycle after the request |
| host_rvalid | output | 1 | Read result valid |
| init_we | input | 1 | Initialisation write strobe |
| init_mask | input | 1 | 1 = size-mask store, 0 = configuration store |
| init_fn | input | $clog2(NFUNC) | Function index into `FUNC_TAGS` |
| init_word | input | $clog2(CFG_BYTES/4) | Word index within the function |
| init_wdata | input | 32 | Initialisation data |

## Verification
The main sweep covers every register offset from 0 up to just past the end of configuration space, with all four access lengths and both byte orders. It runs over three populated functions and one absent one. The sweep separates correct byte assembly and lane order from an off-by-one at the end-of-space boundary, a misdecoded selector field, and a wrong identity answer for absent functions. Directed sizing sequences vary the written value, its length, its offset, the target function, and what kind of read follows. These sequences tell a correct arm/disarm rule apart from a flag that is set too freely, cleared by absent reads, or never cleared.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [3:0] PORT_SEL  = 4'h0;
  localparam logic [3:0] PORT_DATA = 4'h4;
  localparam logic [7:0] BAR_FIRST = 8'h10;
  localparam logic [7:0] BAR_LAST  = 8'h24;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [7:0] regno;
  } cfg_sel_t;
endpackage

// File: rtl/cfg_lane.sv
// Length mask plus optional byte reversal across the active bytes.
module cfg_lane (
  input  logic [31:0] din,
  input  logic [1:0]  len_m1,
  input  logic        swap,
  output logic [31:0] dout
);
  always_comb begin
    dout = '0;
    for (int k = 0; k < 4; k++) begin
      if (k <= int'(len_m1)) begin
        if (swap) dout[k*8 +: 8] = din[(int'(len_m1) - k)*8 +: 8];
        else      dout[k*8 +: 8] = din[k*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/cfg_match.sv
// Compares the selector's bus/device/function against the populated tags.
module cfg_match #(
  parameter int NFUNC = 3,
  parameter logic [16*NFUNC-1:0] TAGS = '0
) (
  input  cfg_pkg::cfg_sel_t         sel,
  output logic                      hit,
  output logic [$clog2(NFUNC)-1:0]  idx
);
  localparam int IDXW = $clog2(NFUNC);
  logic [NFUNC-1:0] m;

  for (genvar i = 0; i < NFUNC; i++) begin : g_cmp
    assign m[i] = ({sel.bus, sel.dev, sel.fn} == TAGS[16*i +: 16]);
  end

  always_comb begin
    hit = |m;
    idx = '0;
    for (int i = NFUNC - 1; i >= 0; i--) begin
      if (m[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/cfg_store.sv
// Per-function word store; reads four consecutive bytes from any byte offset.
module cfg_store #(
  parameter int NFUNC     = 3,
  parameter int CFG_BYTES = 64
) (
  input  logic                             clk,
  input  logic                             wr_en,
  input  logic [$clog2(NFUNC)-1:0]         wr_fn,
  input  logic [$clog2(CFG_BYTES/4)-1:0]   wr_word,
  input  logic [31:0]                      wr_data,
  input  logic [$clog2(NFUNC)-1:0]         rd_fn,
  input  logic [7:0]                       rd_ofs,
  output logic [31:0]                      rd_bytes
);
  localparam int WORDS = CFG_BYTES / 4;
  localparam int WW    = $clog2(WORDS);

  logic [31:0] mem [NFUNC][WORDS];
  logic        wr_ok, rd_ok;

  assign wr_ok = (32'(wr_fn) < NFUNC);
  assign rd_ok = (32'(rd_fn) < NFUNC);

  always_ff @(posedge clk) begin
    if (wr_en && wr_ok) mem[wr_fn][wr_word] <= wr_data;
  end

  for (genvar k = 0; k < 4; k++) begin : g_byte
    logic [8:0] b;
    assign b = {1'b0, rd_ofs} + 9'(k);
    assign rd_bytes[8*k +: 8] = (rd_ok && (b < 9'(CFG_BYTES)))
                              ? mem[rd_fn][b[WW+1:2]][{b[1:0], 3'b000} +: 8]
                              : 8'h00;
  end
endmodule

// File: rtl/cfg_window.sv
module cfg_window #(
  parameter int NFUNC     = 3,
  parameter int CFG_BYTES = 64,
  parameter logic [16*NFUNC-1:0] FUNC_TAGS = {16'h0111, 16'h0008, 16'h0000}
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             host_be,
  input  logic                             host_req,
  input  logic                             host_wr,
  input  logic [3:0]                       host_ofs,
  input  logic [1:0]                       host_len_m1,
  input  logic [31:0]                      host_wdata,
  output logic [31:0]                      host_rdata,
  output logic                             host_rvalid,
  input  logic                             init_we,
  input  logic                             init_mask,
  input  logic [$clog2(NFUNC)-1:0]         init_fn,
  input  logic [$clog2(CFG_BYTES/4)-1:0]   init_word,
  input  logic [31:0]                      init_wdata
);
  import cfg_pkg::*;
  localparam int FNW = $clog2(NFUNC);

  logic [31:0]    sel_q, sel_d;
  logic           sizing_q, sizing_d;
  logic [31:0]    rdata_q, rdata_d;
  logic           rvalid_q, rvalid_d;

  cfg_sel_t       sel;
  logic [7:0]     reg_no;
  logic           fn_hit;
  logic [FNW-1:0] fn_idx;
  logic [31:0]    sel_in, cfg_bytes, mask_bytes, raw_bytes, rd_val, wr_val;
  logic           bar_sel, over_end, is_rd, is_wr;

  assign sel    = cfg_sel_t'(sel_q[23:0]);
  assign reg_no = sel.regno;

  cfg_lane u_sel_swap (.din(host_wdata), .len_m1(2'd3), .swap(host_be), .dout(sel_in));

  cfg_match #(.NFUNC(NFUNC), .TAGS(FUNC_TAGS)) u_match (
    .sel(sel), .hit(fn_hit), .idx(fn_idx));

  cfg_store #(.NFUNC(NFUNC), .CFG_BYTES(CFG_BYTES)) u_cfg (
    .clk(clk), .wr_en(init_we & ~init_mask), .wr_fn(init_fn), .wr_word(init_word),
    .wr_data(init_wdata), .rd_fn(fn_idx), .rd_ofs(reg_no), .rd_bytes(cfg_bytes));

  cfg_store #(.NFUNC(NFUNC), .CFG_BYTES(CFG_BYTES)) u_mask (
    .clk(clk), .wr_en(init_we & init_mask), .wr_fn(init_fn), .wr_word(init_word),
    .wr_data(init_wdata), .rd_fn(fn_idx), .rd_ofs(reg_no), .rd_bytes(mask_bytes));

  assign bar_sel   = (reg_no >= BAR_FIRST) && (reg_no <= BAR_LAST);
  assign over_end  = ({1'b0, reg_no} + {7'b0, host_len_m1}) >= 9'(CFG_BYTES);
  assign raw_bytes = (sizing_q && bar_sel) ? mask_bytes : cfg_bytes;

  cfg_lane u_rd_lane (.din(raw_bytes),  .len_m1(host_len_m1), .swap(host_be), .dout(rd_val));
  cfg_lane u_wr_lane (.din(host_wdata), .len_m1(host_len_m1), .swap(host_be), .dout(wr_val));

  assign is_rd = host_req & ~host_wr;
  assign is_wr = host_req &  host_wr;

  always_comb begin
    sel_d    = sel_q;
    sizing_d = sizing_q;
    rdata_d  = rdata_q;
    rvalid_d = is_rd;
    if (is_rd) begin
      unique case (host_ofs)
        PORT_SEL:  rdata_d = sel_q;
        PORT_DATA: begin
          if (!fn_hit) begin
            rdata_d = (reg_no == 8'h00) ? 32'hFFFF_FFFF : 32'h0;
          end else begin
            rdata_d  = over_end ? 32'h0 : rd_val;
            sizing_d = 1'b0;
          end
        end
        default:   rdata_d = 32'h0;
      endcase
    end
    if (is_wr) begin
      if (host_ofs == PORT_SEL) sel_d = sel_in;
      if ((host_ofs == PORT_DATA) && fn_hit && bar_sel && (wr_val == 32'hFFFF_FFFF))
        sizing_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      sizing_q <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      if (is_wr) sel_q <= sel_d;
      if (host_req) sizing_q <= sizing_d;
      if (is_rd) rdata_q <= rdata_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_req,
  input logic        host_wr,
  input logic [3:0]  host_ofs,
  input logic [1:0]  host_len_m1,
  input logic [31:0] host_wdata,
  input logic [31:0] host_rdata,
  input logic        host_rvalid,
  input logic        fn_hit,
  input logic [7:0]  reg_no,
  input logic        sizing_q,
  input logic        bar_sel
);
  // R11
  read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_wr) |=> host_rvalid);
  // R11
  no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_wr) |=> !host_rvalid);
  // R10
  other_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_wr && host_ofs != 4'h0 && host_ofs != 4'h4) |=> (host_rdata == 32'h0));
  // R3
  absent_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_wr && host_ofs == 4'h4 && !fn_hit && reg_no == 8'h00)
      |=> (host_rdata == 32'hFFFF_FFFF));
  // R3
  absent_keeps_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_wr && host_ofs == 4'h4 && !fn_hit) |=> $stable(sizing_q));
  // R7
  size_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_wr && host_ofs == 4'h4 && fn_hit) |=> !sizing_q);
  // R6
  size_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_wr && host_ofs == 4'h4 && fn_hit && bar_sel &&
     host_len_m1 == 2'd3 && host_wdata == 32'hFFFF_FFFF) |=> sizing_q);
  // R10
  other_port_keeps_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_wr && host_ofs != 4'h4) |=> $stable(sizing_q));
endmodule

bind cfg_window cfg_window_chk u_cfg_window_chk (.*);

// File: tb/test_cfg_window.sv
module test_cfg_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_be, host_req, host_wr;
  logic [3:0]  host_ofs;
  logic [1:0]  host_len_m1;
  logic [31:0] host_wdata, host_rdata;
  logic        host_rvalid;
  logic        init_we, init_mask;
  logic [1:0]  init_fn;
  logic [3:0]  init_word;
  logic [31:0] init_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  cfg_window i_cfg_window (.*);

  int tag_of [4] = '{32'h0000, 32'h0008, 32'h0111, 32'h0009};
  int fn_of  [4] = '{0, 1, 2, -1};

  function automatic logic [7:0] cbyte(int f, int o);
    return 8'((f * 64) ^ (o * 5) ^ 8'hA5);
  endfunction
  function automatic logic [7:0] mbyte(int f, int o);
    return 8'(~(o * 3 + f));
  endfunction
  function automatic logic [31:0] bswap(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] model_rd(int f, int r, int lm1, bit msk, bit be);
    logic [31:0] v = 0;
    logic [31:0] o = 0;
    if (f < 0) return (r == 0) ? 32'hFFFF_FFFF : 32'h0;
    if (r + lm1 >= 64) return 32'h0;
    for (int k = 0; k <= lm1; k++)
      v[8*k +: 8] = (msk && r >= 16 && r <= 36) ? mbyte(f, r + k) : cbyte(f, r + k);
    if (!be) return v;
    for (int k = 0; k <= lm1; k++) o[8*k +: 8] = v[8*(lm1 - k) +: 8];
    return o;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [3:0] ofs, logic [1:0] lm1, logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_wr = 1; host_ofs = ofs; host_len_m1 = lm1; host_wdata = d;
    @(negedge clk);
    host_req = 0; host_wr = 0;
  endtask

  task automatic host_read(logic [3:0] ofs, logic [1:0] lm1, output logic [31:0] d,
                           output logic v);
    @(negedge clk);
    host_req = 1; host_wr = 0; host_ofs = ofs; host_len_m1 = lm1;
    @(negedge clk);
    host_req = 0;
    d = host_rdata; v = host_rvalid;
  endtask

  task automatic set_sel(int t, int r);
    logic [31:0] val = {8'h00, 16'(tag_of[t]), 8'(r)};
    host_write(4'h0, 2'd3, host_be ? bswap(val) : val);
  endtask

  task automatic rd_data(int lm1, output logic [31:0] d);
    logic v;
    host_read(4'h4, 2'(lm1), d, v);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    rst_n = 0; host_be = 0; host_req = 0; host_wr = 0; host_ofs = 0;
    host_len_m1 = 0; host_wdata = 0;
    init_we = 0; init_mask = 0; init_fn = 0; init_word = 0; init_wdata = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset rvalid", 32'(host_rvalid), 0);
    chk("R11 reset rdata", host_rdata, 0);
    rst_n = 1;

    // R12 load both stores
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 3; f++)
        for (int w = 0; w < 16; w++) begin
          @(negedge clk);
          init_we = 1; init_mask = m[0]; init_fn = 2'(f); init_word = 4'(w);
          for (int k = 0; k < 4; k++)
            init_wdata[8*k +: 8] = m ? mbyte(f, 4*w + k) : cbyte(f, 4*w + k);
        end
    @(negedge clk); init_we = 0;

    // R1 selector after reset
    host_read(4'h0, 2'd3, d, v);
    chk("R1 selector reset", d, 0);
    chk("R11 rvalid after read", 32'(v), 1);

    // R2 R4 R5 R9 R12 full sweep
    for (int be = 0; be < 2; be++) begin
      host_be = be[0];
      for (int t = 0; t < 4; t++) begin
        set_sel(t, 8'h3C);
        host_read(4'h0, 2'd3, d, v);
        chk("R1 selector readback", d, {8'h00, 16'(tag_of[t]), 8'h3C});
        for (int r = 0; r < 67; r++)
          for (int l = 0; l < 4; l++) begin
            set_sel(t, r);
            rd_data(l, d);
            chk("R2 R4 R5 R9 R3 sweep", d, model_rd(fn_of[t], r, l, 0, be[0]));
          end
      end
    end
    host_be = 0;

    // R6 R7 arm then one masked read
    set_sel(1, 8'h14);
    host_write(4'h4, 2'd3, 32'hFFFF_FFFF);
    rd_data(3, d);
    chk("R6 mask after arm", d, model_rd(1, 8'h14, 3, 1, 0));
    rd_data(3, d);
    chk("R7 cleared after read", d, model_rd(1, 8'h14, 3, 0, 0));

    // R6 armed state applies to other function; partial mask read
    set_sel(0, 8'h10);
    host_write(4'h4, 2'd3, 32'hFFFF_FFFF);
    set_sel(2, 8'h22);
    rd_data(1, d);
    chk("R6 mask other fn len2", d, model_rd(2, 8'h22, 1, 1, 0));

    // R6 no arm outside range
    set_sel(0, 8'h28);
    host_write(4'h4, 2'd3, 32'hFFFF_FFFF);
    set_sel(0, 8'h10);
    rd_data(3, d);
    chk("R6 no arm at 0x28", d, model_rd(0, 8'h10, 3, 0, 0));

    // R6 no arm with short write / other value
    host_write(4'h4, 2'd1, 32'hFFFF_FFFF);
    rd_data(3, d);
    chk("R6 no arm len2", d, model_rd(0, 8'h10, 3, 0, 0));
    host_write(4'h4, 2'd3, 32'hFFFF_FFFE);
    rd_data(3, d);
    chk("R6 no arm other value", d, model_rd(0, 8'h10, 3, 0, 0));

    // R6 no arm on absent function
    set_sel(3, 8'h10);
    host_write(4'h4, 2'd3, 32'hFFFF_FFFF);
    set_sel(0, 8'h10);
    rd_data(3, d);
    chk("R6 no arm absent fn", d, model_rd(0, 8'h10, 3, 0, 0));

    // R3 absent read keeps armed state
    set_sel(0, 8'h18);
    host_write(4'h4, 2'd3, 32'hFFFF_FFFF);
    set_sel(3, 0);
    rd_data(3, d);
    chk("R3 absent id", d, 32'hFFFF_FFFF);
    set_sel(0, 8'h18);
    rd_data(3, d);
    chk("R3 absent read keeps sizing", d, model_rd(0, 8'h18, 3, 1, 0));

    // R7 read outside range also disarms
    host_write(4'h4, 2'd3, 32'hFFFF_FFFF);
    set_sel(0, 8'h00);
    rd_data(3, d);
    chk("R7 non-bar read normal", d, model_rd(0, 0, 3, 0, 0));
    set_sel(0, 8'h18);
    rd_data(3, d);
    chk("R7 disarmed by non-bar read", d, model_rd(0, 8'h18, 3, 0, 0));

    // R9 big-endian sizing and masked read
    host_be = 1;
    set_sel(2, 8'h20);
    host_write(4'h4, 2'd3, 32'hFFFF_FFFF);
    rd_data(2, d);
    chk("R9 R6 be mask len3", d, model_rd(2, 8'h20, 2, 1, 1));
    host_be = 0;

    // R8 writes do not change contents
    set_sel(1, 8'h04);
    host_write(4'h4, 2'd3, 32'h1234_5678);
    rd_data(3, d);
    chk("R8 cfg unchanged", d, model_rd(1, 4, 3, 0, 0));
    set_sel(1, 8'h1C);
    host_write(4'h4, 2'd3, 32'h0BAD_F00D);
    rd_data(3, d);
    chk("R8 bar unchanged", d, model_rd(1, 8'h1C, 3, 0, 0));
    host_write(4'h4, 2'd3, 32'hFFFF_FFFF);
    rd_data(3, d);
    chk("R8 mask store intact", d, model_rd(1, 8'h1C, 3, 1, 0));

    // R10 other ports
    set_sel(2, 8'h08);
    host_write(4'h8, 2'd3, 32'hDEAD_BEEF);
    host_write(4'hC, 2'd3, 32'hFFFF_FFFF);
    host_read(4'h8, 2'd3, d, v);
    chk("R10 other port reads zero", d, 0);
    chk("R11 rvalid other port", 32'(v), 1);
    host_read(4'hF, 2'd3, d, v);
    chk("R10 port 0xF reads zero", d, 0);
    host_read(4'h0, 2'd3, d, v);
    chk("R10 selector untouched", d, {8'h00, 16'h0111, 8'h08});
    rd_data(3, d);
    chk("R10 no arm via other port", d, model_rd(2, 8'h08, 3, 0, 0));

    // R11 write gives no rvalid
    host_write(4'h0, 2'd3, 32'h0000_0000);
    chk("R11 no rvalid after write", 32'(host_rvalid), 0);
    // R1 be swap of selector
    host_be = 1;
    host_write(4'h0, 2'd3, 32'h1122_3344);
    host_read(4'h0, 2'd3, d, v);
    chk("R1 be selector swapped", d, 32'h4433_2211);
    host_be = 0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule